// File: doc/BRIEF.md
# Registered Word Exchanger Between One Narrow Port and Two Banked Ports

This block connects one narrow bidirectional port (A) to two banked bidirectional ports of the same width (B1 and B2). Traffic from A towards the banks goes into two registers, one for each bank. Each register has its own active-low load enable. A controller can therefore place two successive A words in the two banks and then present them as a single double-width word across B1 and B2. This suits a narrow processor bus that feeds an interleaved pair of memory banks.

Traffic from the banks towards A goes through a single register. That register loads on every clock edge. A select line, sampled at the same edge, decides whether it takes bank B1 or bank B2. Each port has an active-low output disable, and that disable is registered, so every change on a port takes effect one clock edge later.

Each bidirectional pin is split into three signals: an input value, an output value and a drive flag. A per-port flag tells the block whether the far side is driving the pin. When neither side drives a pin, a bus keeper holds its last value. When only the block drives it, the register inputs see the block's own output.

Top module: `word_exchanger`

## Requirements
- R1: At a rising edge with `loadB1N` low, the B1 bank register takes the current A pin value, and `b1Out` shows it after that edge. With `loadB1N` high, `b1Out` is unchanged.
- R2: At a rising edge with `loadB2N` low, the B2 bank register takes the current A pin value, and `b2Out` shows it after that edge. With `loadB2N` high, `b2Out` is unchanged.
- R3: Loading word W0 into B1 at one edge and word W1 into B2 at the next edge gives {`b2Out`,`b1Out`} = {W1,W0}. Both bank drives can be switched on at the second of those edges.
- R4: At every rising edge the A register loads. It takes the B1 pin value when `pickB1` is 1 and the B2 pin value when `pickB1` is 0. `aOut` shows the result after that edge.
- R5: `aDrive`, `b1Drive` and `b2Drive` each equal the inverse of `disAN`, `disB1N` and `disB2N` as sampled at the most recent rising edge. A change on a disable input does not reach the drive flag before that edge.
- R6: A port whose registered disable is 1 keeps its drive flag at 0. A port whose registered disable is 0 drives its register on its out bus. The A port and the B ports switch independently, and all four A/B1 combinations are legal, including both active at once.
- R7: Bus hold. When the external drive flag for a port (`aExt`, `b1Ext`, `b2Ext`) is 0 and the block is not driving that port, the value the registers see on that pin is the last value the pin held.
- R8: When the external drive flag for a port is 0 and the block is driving that port, the registers see the block's own output value on that pin. An external driver has priority over the block's own output.
- R9: At a rising edge with `rst` high, the block clears all three data registers to 0 and sets all drive flags to 0 (all ports disabled).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything samples on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| aIn | input | WORD | Value applied to the A pins from outside |
| aExt | input | 1 | 1 when the outside drives the A pins |
| aOut | output | WORD | A register contents |
| aDrive | output | 1 | 1 when the block drives the A pins |
| b1In | input | WORD | Value applied to the B1 pins from outside |
| b1Ext | input | 1 | 1 when the outside drives the B1 pins |
| b1Out | output | WORD | B1 bank register contents |
| b1Drive | output | 1 | 1 when the block drives the B1 pins |
| b2In | input | WORD | Value applied to the B2 pins from outside |
| b2Ext | input | 1 | 1 when the outside drives the B2 pins |
| b2Out | output | WORD | B2 bank register contents |
| b2Drive | output | 1 | 1 when the block drives the B2 pins |
| loadB1N | input | 1 | Active-low load enable of the B1 bank register |
| loadB2N | input | 1 | Active-low load enable of the B2 bank register |
| pickB1 | input | 1 | 1 selects B1, 0 selects B2, as the source of the A register |
| disAN | input | 1 | Active-low enable of the A output driver; 1 disables it (registered) |
| disB1N | input | 1 | Active-low enable of the B1 output driver; 1 disables it (registered) |
| disB2N | input | 1 | Active-low enable of the B2 output driver; 1 disables it (registered) |

## Verification
The assertions check the following relations on every cycle:
- each bank register either loads the A pin value or holds, as its enable says;
- the A register follows the select one edge later;
- each drive flag follows its disable input one edge later;
- the keeper repeats the previous pin value whenever no one drives the pin;
- reset leaves every drive flag at 0 and every register at 0.

Only the bench scenarios can show the behaviours that span more than one step. These are the two-edge assembly of a double-width word, the loop in which a B bank's own output comes back into the A register, and bus hold across several idle cycles on both the A and B sides.

// File: rtl/xchg_pkg.sv
package xchg_pkg;

  // Strobes passed from the control module to the datapath
  typedef struct packed {
    logic loadB1;   // capture the A pin value into bank B1
    logic loadB2;   // capture the A pin value into bank B2
    logic pickB1;   // A register source: 1 = B1 pin, 0 = B2 pin
    logic driveA;   // registered drive flag for port A
    logic driveB1;  // registered drive flag for port B1
    logic driveB2;  // registered drive flag for port B2
  } xchgStrobes_t;

  localparam int PORTS = 3;
  localparam int PORT_A = 0;
  localparam int PORT_B1 = 1;
  localparam int PORT_B2 = 2;

endpackage

// File: rtl/xchg_keeper.sv
module xchg_keeper #(
  parameter int WORD = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [WORD-1:0] extIn,
  input  logic            extDrv,
  input  logic [WORD-1:0] ownVal,
  input  logic            ownDrv,
  output logic [WORD-1:0] pinVal
);

  logic [WORD-1:0] heldVal;

  // Pin resolution: the external driver wins, then the block's own driver,
  // and when no one drives the pin the keeper's held value is used.
  always_comb begin
    if (extDrv)      pinVal = extIn;
    else if (ownDrv) pinVal = ownVal;
    else             pinVal = heldVal;
  end

  always_ff @(posedge clk) begin
    if (rst) heldVal <= '0;
    else     heldVal <= pinVal;
  end

  // R7: a pin that no one drives keeps the value it had one cycle earlier
  assert_pin_kept_R7: assert property (@(posedge clk) disable iff (rst)
    (!extDrv && !ownDrv && !$past(rst)) |-> (pinVal == $past(pinVal)));

  // R8: the external driver overrides the block's own output on the pin
  assert_ext_priority_R8: assert property (@(posedge clk) disable iff (rst)
    extDrv |-> (pinVal == extIn));

endmodule

// File: rtl/xchg_ctrl.sv
module xchg_ctrl
  import xchg_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         loadB1N,
  input  logic         loadB2N,
  input  logic         pickB1,
  input  logic         disAN,
  input  logic         disB1N,
  input  logic         disB2N,
  output xchgStrobes_t strobes
);

  logic driveAQ, driveB1Q, driveB2Q;

  // The disables are active low and registered: they take effect one edge later
  always_ff @(posedge clk) begin
    if (rst) begin
      driveAQ  <= 1'b0;
      driveB1Q <= 1'b0;
      driveB2Q <= 1'b0;
    end else begin
      driveAQ  <= ~disAN;
      driveB1Q <= ~disB1N;
      driveB2Q <= ~disB2N;
    end
  end

  // Load enables and the select are only used at the capturing edge
  always_comb begin
    strobes.loadB1  = ~loadB1N;
    strobes.loadB2  = ~loadB2N;
    strobes.pickB1  = pickB1;
    strobes.driveA  = driveAQ;
    strobes.driveB1 = driveB1Q;
    strobes.driveB2 = driveB2Q;
  end

  // R5: each drive flag follows its disable input one edge later
  assert_drive_on_R5: assert property (@(posedge clk) disable iff (rst)
    !disAN |=> strobes.driveA);
  assert_drive_off_R5: assert property (@(posedge clk) disable iff (rst)
    disAN |=> !strobes.driveA);
  assert_b1_latency_R5: assert property (@(posedge clk) disable iff (rst)
    !disB1N |=> strobes.driveB1);
  assert_b2_latency_R5: assert property (@(posedge clk) disable iff (rst)
    disB2N |=> !strobes.driveB2);

endmodule

// File: rtl/xchg_datapath.sv
module xchg_datapath
  import xchg_pkg::*;
#(
  parameter int WORD = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  xchgStrobes_t    strobes,
  input  logic [WORD-1:0] aIn,
  input  logic            aExt,
  input  logic [WORD-1:0] b1In,
  input  logic            b1Ext,
  input  logic [WORD-1:0] b2In,
  input  logic            b2Ext,
  output logic [WORD-1:0] aOut,
  output logic [WORD-1:0] b1Out,
  output logic [WORD-1:0] b2Out
);

  logic [WORD-1:0]  extInArr [PORTS];
  logic [WORD-1:0]  ownValArr[PORTS];
  logic [WORD-1:0]  pinArr   [PORTS];
  logic [PORTS-1:0] extDrvArr;
  logic [PORTS-1:0] ownDrvArr;

  logic [WORD-1:0] regA, bankB1, bankB2;

  always_comb begin
    extInArr[PORT_A]   = aIn;
    extInArr[PORT_B1]  = b1In;
    extInArr[PORT_B2]  = b2In;
    ownValArr[PORT_A]  = regA;
    ownValArr[PORT_B1] = bankB1;
    ownValArr[PORT_B2] = bankB2;
    extDrvArr = {b2Ext, b1Ext, aExt};
    ownDrvArr = {strobes.driveB2, strobes.driveB1, strobes.driveA};
  end

  // One keeper for each bidirectional port
  for (genvar p = 0; p < PORTS; p++) begin : g_keep
    xchg_keeper #(.WORD(WORD)) u_keeper (
      .clk    (clk),
      .rst    (rst),
      .extIn  (extInArr[p]),
      .extDrv (extDrvArr[p]),
      .ownVal (ownValArr[p]),
      .ownDrv (ownDrvArr[p]),
      .pinVal (pinArr[p])
    );
  end

  // Bank registers in the A-to-B direction, each with its own enable
  always_ff @(posedge clk) begin
    if (rst) begin
      bankB1 <= '0;
      bankB2 <= '0;
    end else begin
      if (strobes.loadB1) bankB1 <= pinArr[PORT_A];
      if (strobes.loadB2) bankB2 <= pinArr[PORT_A];
    end
  end

  // Single register in the B-to-A direction; loads on every edge from the selected bank
  always_ff @(posedge clk) begin
    if (rst) regA <= '0;
    else     regA <= strobes.pickB1 ? pinArr[PORT_B1] : pinArr[PORT_B2];
  end

  assign aOut  = regA;
  assign b1Out = bankB1;
  assign b2Out = bankB2;

  // R1: bank B1 loads the A pin value or holds
  assert_b1_load_R1: assert property (@(posedge clk) disable iff (rst)
    strobes.loadB1 |=> (bankB1 == $past(pinArr[PORT_A])));
  assert_b1_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !strobes.loadB1 |=> $stable(bankB1));

  // R2: bank B2 loads the A pin value or holds
  assert_b2_load_R2: assert property (@(posedge clk) disable iff (rst)
    strobes.loadB2 |=> (bankB2 == $past(pinArr[PORT_A])));
  assert_b2_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !strobes.loadB2 |=> $stable(bankB2));

  // R4: the A register follows the sampled select
  assert_pick_b1_R4: assert property (@(posedge clk) disable iff (rst)
    strobes.pickB1 |=> (regA == $past(pinArr[PORT_B1])));
  assert_pick_b2_R4: assert property (@(posedge clk) disable iff (rst)
    !strobes.pickB1 |=> (regA == $past(pinArr[PORT_B2])));

endmodule

// File: rtl/word_exchanger.sv
module word_exchanger
  import xchg_pkg::*;
#(
  parameter int WORD = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [WORD-1:0] aIn,
  input  logic            aExt,
  output logic [WORD-1:0] aOut,
  output logic            aDrive,
  input  logic [WORD-1:0] b1In,
  input  logic            b1Ext,
  output logic [WORD-1:0] b1Out,
  output logic            b1Drive,
  input  logic [WORD-1:0] b2In,
  input  logic            b2Ext,
  output logic [WORD-1:0] b2Out,
  output logic            b2Drive,
  input  logic            loadB1N,
  input  logic            loadB2N,
  input  logic            pickB1,
  input  logic            disAN,
  input  logic            disB1N,
  input  logic            disB2N
);

  xchgStrobes_t strobes;

  xchg_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .loadB1N (loadB1N),
    .loadB2N (loadB2N),
    .pickB1  (pickB1),
    .disAN   (disAN),
    .disB1N  (disB1N),
    .disB2N  (disB2N),
    .strobes (strobes)
  );

  xchg_datapath #(.WORD(WORD)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .aIn     (aIn),
    .aExt    (aExt),
    .b1In    (b1In),
    .b1Ext   (b1Ext),
    .b2In    (b2In),
    .b2Ext   (b2Ext),
    .aOut    (aOut),
    .b1Out   (b1Out),
    .b2Out   (b2Out)
  );

  assign aDrive  = strobes.driveA;
  assign b1Drive = strobes.driveB1;
  assign b2Drive = strobes.driveB2;

  // R9: a reset edge leaves every port disabled and every register cleared
  assert_reset_state_R9: assert property (@(posedge clk)
    rst |=> (!aDrive && !b1Drive && !b2Drive &&
             aOut == '0 && b1Out == '0 && b2Out == '0));

  // R6: the A and B1 drivers switch independently, both active at once included
  assert_both_active_R6: assert property (@(posedge clk) disable iff (rst)
    (!disAN && !disB1N) |=> (aDrive && b1Drive));
  assert_split_R6: assert property (@(posedge clk) disable iff (rst)
    (disAN && !disB2N) |=> (!aDrive && b2Drive));

endmodule

// File: tb/test_word_exchanger.sv
module test_word_exchanger;

  localparam int WORD = 12;

  logic            clk = 1'b0;
  logic            rst;
  logic [WORD-1:0] aIn, b1In, b2In;
  logic            aExt, b1Ext, b2Ext;
  logic [WORD-1:0] aOut, b1Out, b2Out;
  logic            aDrive, b1Drive, b2Drive;
  logic            loadB1N, loadB2N, pickB1;
  logic            disAN, disB1N, disB2N;

  int nVec = 0;
  int nBad = 0;

  always #4 clk = ~clk;  // 125 MHz

  word_exchanger #(.WORD(WORD)) i_word_exchanger (
    .clk(clk), .rst(rst),
    .aIn(aIn), .aExt(aExt), .aOut(aOut), .aDrive(aDrive),
    .b1In(b1In), .b1Ext(b1Ext), .b1Out(b1Out), .b1Drive(b1Drive),
    .b2In(b2In), .b2Ext(b2Ext), .b2Out(b2Out), .b2Drive(b2Drive),
    .loadB1N(loadB1N), .loadB2N(loadB2N), .pickB1(pickB1),
    .disAN(disAN), .disB1N(disB1N), .disB2N(disB2N)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] actual, input logic [31:0] expected);
    nVec++;
    if (actual !== expected) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, actual, expected);
    end
  endtask

  // one rising edge, then return at the following falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    aIn = '0; b1In = '0; b2In = '0;
    aExt = 1'b1; b1Ext = 1'b1; b2Ext = 1'b1;
    loadB1N = 1'b1; loadB2N = 1'b1; pickB1 = 1'b1;
    disAN = 1'b1; disB1N = 1'b1; disB2N = 1'b1;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic t_reset();  // R9
    aIn = 12'hFFF; loadB1N = 1'b0; loadB2N = 1'b0; disAN = 1'b0;
    rst = 1'b1;
    step();
    check("R9", "aDrive", aDrive, 0);
    check("R9", "b1Drive", b1Drive, 0);
    check("R9", "b2Drive", b2Drive, 0);
    check("R9", "aOut", aOut, 0);
    check("R9", "b1Out", b1Out, 0);
    check("R9", "b2Out", b2Out, 0);
    rst = 1'b0;
    idle_inputs();
  endtask

  task automatic t_banks();  // R1, R2
    aIn = 12'h5A3; loadB1N = 1'b0;
    step();
    check("R1", "b1 load", b1Out, 12'h5A3);
    check("R2", "b2 untouched", b2Out, 0);
    aIn = 12'h111; loadB1N = 1'b1;
    step();
    check("R1", "b1 hold", b1Out, 12'h5A3);
    aIn = 12'h2C7; loadB2N = 1'b0;
    step();
    check("R2", "b2 load", b2Out, 12'h2C7);
    check("R1", "b1 hold while b2 loads", b1Out, 12'h5A3);
    aIn = 12'h999; loadB2N = 1'b1;
    step();
    check("R2", "b2 hold", b2Out, 12'h2C7);
  endtask

  task automatic t_pair();  // R3
    aIn = 12'hDEA; loadB1N = 1'b0;
    step();
    aIn = 12'h0BE; loadB1N = 1'b1; loadB2N = 1'b0; disB1N = 1'b0; disB2N = 1'b0;
    step();
    loadB2N = 1'b1;
    check("R3", "joined word", {b2Out, b1Out}, {12'h0BE, 12'hDEA});
    check("R3", "both bank drives", {b2Drive, b1Drive}, 2'b11);
    disB1N = 1'b1; disB2N = 1'b1;
    step();
  endtask

  task automatic t_pick();  // R4
    b1In = 12'hABC; b2In = 12'h123; pickB1 = 1'b1;
    step();
    check("R4", "pick B1", aOut, 12'hABC);
    pickB1 = 1'b0;
    #1;
    check("R4", "no change before edge", aOut, 12'hABC);
    step();
    check("R4", "pick B2", aOut, 12'h123);
    b2In = 12'h777;
    step();
    check("R4", "reloads every edge", aOut, 12'h777);
  endtask

  task automatic t_latency();  // R5
    disAN = 1'b0;
    #1;
    check("R5", "aDrive before edge", aDrive, 0);
    step();
    check("R5", "aDrive after edge", aDrive, 1);
    disAN = 1'b1;
    #1;
    check("R5", "aDrive held before edge", aDrive, 1);
    step();
    check("R5", "aDrive released", aDrive, 0);
    disB2N = 1'b0;
    step();
    check("R5", "b2Drive after edge", b2Drive, 1);
    disB2N = 1'b1;
    step();
    check("R5", "b2Drive released", b2Drive, 0);
  endtask

  task automatic t_combos();  // R6
    for (int c = 0; c < 4; c++) begin
      disAN = c[0]; disB1N = c[1];
      step();
      check("R6", "aDrive combo", aDrive, !c[0]);
      check("R6", "b1Drive combo", b1Drive, !c[1]);
      check("R6", "b2 stays off", b2Drive, 0);
    end
    disAN = 1'b1; disB1N = 1'b1;
    step();
  endtask

  task automatic t_hold();  // R7
    b2In = 12'h3C5; pickB1 = 1'b0;
    step();
    b2Ext = 1'b0; b2In = 12'hFFF;
    step(); step();
    check("R7", "B2 kept value into A", aOut, 12'h3C5);
    b2Ext = 1'b1;
    aIn = 12'h6E1;
    step();
    aExt = 1'b0; aIn = 12'h000; loadB1N = 1'b0;
    step(); step();
    check("R7", "A kept value into B1", b1Out, 12'h6E1);
    aExt = 1'b1; loadB1N = 1'b1;
    step();
  endtask

  task automatic t_loop();  // R8
    aIn = 12'h4D2; loadB1N = 1'b0; disB1N = 1'b0;
    step();
    loadB1N = 1'b1; b1Ext = 1'b0; b1In = 12'h00F; pickB1 = 1'b1;
    step();
    check("R8", "own B1 output into A", aOut, 12'h4D2);
    b1Ext = 1'b1; b1In = 12'h8A8;
    step();
    check("R8", "external wins over own output", aOut, 12'h8A8);
    disB1N = 1'b1;
    step();
  endtask

  initial begin
    #(8 * 200000);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    idle_inputs();
    rst = 1'b1;
    @(negedge clk);
    t_reset();
    do_reset();
    t_banks();
    t_pair();
    do_reset();
    t_pick();
    t_latency();
    t_combos();
    t_hold();
    do_reset();
    t_loop();
    $display("  == %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule